// File: doc/BRIEF.md
# Long-Press Push-Button Reset Controller

This block turns a single active-low push-button into a guarded system reset. A short tap, which software may treat as an interrupt, never reaches the reset output. Only a press that stays down without a break for the configured setup delay asserts the reset. The delay is chosen with a 5-bit step code. Each step is 500 ticks of the one-millisecond tick enable, and the code ranges from 1 (0.5 s) to 20 (10 s). Two release policies are available. In push-button mode the reset follows the button and ends as soon as the button is let go. In fixed-pulse mode the reset lasts a set number of ticks, whatever the button does.

A rising test-entry request puts the block into a test mode. This mode stays set until the next power-on reset. On entry, an initial delay of 42 ticks runs. A feedback reset then shows that entry took place. While the block is in test mode, every setup delay is divided by 128. This lets a production test exercise the long-press path quickly.

The button and the test request each pass through a two-flop synchronizer. The block has no data stream, so every pin is a plain level or a single-cycle strobe. Nothing in it applies back-pressure.

Top module: `lpr_reset_ctrl`

## Requirements
- R1: After power-on reset the block is in normal mode and the reset output is inactive. With the default active-low polarity, `rst_out` reads 1 when inactive and 0 when asserted.
- R2: The reset asserts only after the button has been held continuously for `delay_code` × 500 ticks. If the button is released earlier, no reset occurs, and the next press times its hold again from zero.
- R3: A `delay_code` of 0 is treated as 1. A code above 20 is treated as 20. This applies in both normal mode and test mode.
- R4: With `fixed_pulse` = 0, the reset stays asserted while the button is held and ends when the button is released. There is no minimum pulse width.
- R5: With `fixed_pulse` = 1, the reset lasts exactly 210 ticks when `long_pulse` = 0 and 360 ticks when `long_pulse` = 1, regardless of the button.
- R6: After a reset has ended, the button must go inactive before a new hold is timed. One continuous press produces only one reset.
- R7: A low-to-high change of `test_req` enters test mode. After 42 ticks a feedback reset asserts. With `fixed_pulse` = 1 the feedback lasts the fixed duration. With `fixed_pulse` = 0 it lasts while `test_req` stays high.
- R8: In test mode the hold delay is (clamped code × 500) shifted right by 7, with a minimum of 1 tick.
- R9: Test mode ends only on power-on reset. A new `test_req` rise while in test mode is ignored and produces no reset.
- R10: If `test_req` is already high when power-on reset releases, the block does not enter test mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tick_ms | input | 1 | One-cycle strobe every millisecond; all timing advances on it |
| btn_n | input | 1 | Debounced push-button, active low, asynchronous |
| test_req | input | 1 | Test-entry request, active high, asynchronous |
| delay_code | input | 5 | Setup delay in 500-tick steps (1 to 20) |
| fixed_pulse | input | 1 | 1 selects fixed-length reset, 0 selects push-button controlled |
| long_pulse | input | 1 | In fixed mode, 1 selects 360 ticks and 0 selects 210 ticks |
| rst_out | output | 1 | Reset output; polarity set by the RST_ACTIVE_LOW parameter |

## Verification
Several behaviours are checked by assertions on every cycle:
- test mode never clears once it is set;
- each reset rise is preceded by a timer completion;
- a button release ends a push-button reset in the next cycle;
- a fixed pulse is not cut short by the button;
- no reset asserts while the block waits for a release;
- the tick counter stays below its nonzero limit.

Some behaviours can only be shown by the bench scenarios, which measure them in ticks at the pins:
- the actual delay lengths, including code clamping and the divide-by-128 in test mode;
- the 42-tick entry delay;
- the restart of an interrupted hold;
- the power-on guard against a request that is already high.

// File: rtl/lpr_pkg.sv
package lpr_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,  // button released, nothing timed
    S_HOLD  = 3'd1,  // timing a continuous press
    S_RBTN  = 3'd2,  // reset follows the button
    S_PULSE = 3'd3,  // fixed-length reset
    S_WAIT  = 3'd4,  // waiting for button release
    S_TINI  = 3'd5,  // test entry delay
    S_TRST  = 3'd6   // test feedback while request held
  } lpr_state_e;

  typedef enum logic [1:0] {
    LIM_HOLD  = 2'd0,
    LIM_PULSE = 2'd1,
    LIM_ENTRY = 2'd2
  } lpr_lim_e;

endpackage

// File: rtl/lpr_sync.sv
module lpr_sync #(
  parameter int              W       = 2,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) sh <= {STAGES{RST_VAL[i]}};
      else        sh <= {sh[STAGES-2:0], d[i]};
    end
    assign q[i] = sh[STAGES-1];
  end

endmodule

// File: rtl/lpr_limits.sv
module lpr_limits #(
  parameter int CODE_W         = 5,
  parameter int CNT_W          = 14,
  parameter int TICKS_PER_STEP = 500,
  parameter int MAX_STEPS      = 20,
  parameter int TEST_SHIFT     = 7,
  parameter int PULSE_SHORT    = 210,
  parameter int PULSE_LONG     = 360
) (
  input  logic [CODE_W-1:0] delay_code,
  input  logic              test_mode,
  input  logic              long_pulse,
  output logic [CNT_W-1:0]  hold_lim,
  output logic [CNT_W-1:0]  pulse_lim
);

  logic [CODE_W-1:0] code_c;
  logic [CNT_W-1:0]  norm_ticks;
  logic [CNT_W-1:0]  short_ticks;

  // R3: clamp the step code into the supported range
  always_comb begin
    if (delay_code == '0)                         code_c = CODE_W'(1);
    else if (delay_code > CODE_W'(MAX_STEPS))     code_c = CODE_W'(MAX_STEPS);
    else                                          code_c = delay_code;
  end

  assign norm_ticks = CNT_W'(code_c) * CNT_W'(TICKS_PER_STEP);

  // R8: shortened delay, never below one tick
  always_comb begin
    short_ticks = norm_ticks >> TEST_SHIFT;
    if (short_ticks == '0) short_ticks = CNT_W'(1);
  end

  assign hold_lim  = test_mode  ? short_ticks : norm_ticks;
  assign pulse_lim = long_pulse ? CNT_W'(PULSE_LONG) : CNT_W'(PULSE_SHORT);

endmodule

// File: rtl/lpr_tick_timer.sv
module lpr_tick_timer #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             tick,
  input  logic             en,
  input  logic             clr,
  input  logic [CNT_W-1:0] lim,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  assign done = en && tick && (cnt == lim - CNT_W'(1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (en && tick) cnt <= done ? '0 : cnt + CNT_W'(1);
  end

  AST_LIM_NONZERO: assert property (@(posedge clk) disable iff (!por_n)
    en |-> (lim != '0)); // R8

  AST_CNT_BELOW_LIM: assert property (@(posedge clk) disable iff (!por_n)
    en |-> (cnt < lim)); // R2

endmodule

// File: rtl/lpr_fsm.sv
module lpr_fsm
  import lpr_pkg::*;
(
  input  logic     clk,
  input  logic     por_n,
  input  logic     btn_act,
  input  logic     treq_s,
  input  logic     fixed_pulse,
  input  logic     tmr_done,
  output logic     tmr_en,
  output logic     tmr_clr,
  output lpr_lim_e lim_sel,
  output logic     test_mode,
  output logic     rst_act
);

  lpr_state_e state, nxt;
  logic       treq_q;
  logic       entry;

  // R10: request history starts high, so a level present at release is no edge
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) treq_q <= 1'b1;
    else        treq_q <= treq_s;
  end

  assign entry = treq_s && !treq_q && !test_mode;

  // R9: sticky until power-on reset
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     test_mode <= 1'b0;
    else if (entry) test_mode <= 1'b1;
  end

  always_comb begin
    nxt = state;
    if (entry) begin
      nxt = S_TINI;
    end else begin
      unique case (state)
        S_IDLE:  if (btn_act) nxt = S_HOLD;
        S_HOLD: begin
          if (!btn_act)     nxt = S_IDLE;
          else if (tmr_done) nxt = fixed_pulse ? S_PULSE : S_RBTN;
        end
        S_RBTN:  if (!btn_act) nxt = S_IDLE;
        S_PULSE: if (tmr_done) nxt = S_WAIT;
        S_WAIT:  if (!btn_act) nxt = S_IDLE;
        S_TINI: begin
          if (tmr_done) begin
            if (fixed_pulse) nxt = S_PULSE;
            else             nxt = treq_s ? S_TRST : S_WAIT;
          end
        end
        S_TRST:  if (!treq_s) nxt = S_WAIT;
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) state <= S_IDLE;
    else        state <= nxt;
  end

  assign tmr_clr = (nxt != state);
  assign tmr_en  = (state == S_HOLD) || (state == S_PULSE) || (state == S_TINI);

  always_comb begin
    unique case (state)
      S_PULSE: lim_sel = LIM_PULSE;
      S_TINI:  lim_sel = LIM_ENTRY;
      default: lim_sel = LIM_HOLD;
    endcase
  end

  assign rst_act = (state == S_RBTN) || (state == S_PULSE) || (state == S_TRST);

  AST_TEST_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    test_mode |=> test_mode); // R9

  AST_RISE_AFTER_TIMER: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_act) |-> $past(tmr_done)); // R2

  AST_RELEASE_ENDS: assert property (@(posedge clk) disable iff (!por_n)
    (state == S_RBTN && !btn_act) |=> !rst_act); // R4

  AST_PULSE_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
    (state == S_PULSE && !tmr_done && !entry) |=> rst_act); // R5

  AST_WAIT_NO_RESET: assert property (@(posedge clk) disable iff (!por_n)
    (state == S_WAIT) |=> !rst_act); // R6

endmodule

// File: rtl/lpr_reset_ctrl.sv
module lpr_reset_ctrl
  import lpr_pkg::*;
#(
  parameter int   CODE_W         = 5,
  parameter int   TICKS_PER_STEP = 500,
  parameter int   MAX_STEPS      = 20,
  parameter int   TEST_SHIFT     = 7,
  parameter int   ENTRY_TICKS    = 42,
  parameter int   PULSE_SHORT    = 210,
  parameter int   PULSE_LONG     = 360,
  parameter int   SYNC_STAGES    = 2,
  parameter logic RST_ACTIVE_LOW = 1'b1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              tick_ms,
  input  logic              btn_n,
  input  logic              test_req,
  input  logic [CODE_W-1:0] delay_code,
  input  logic              fixed_pulse,
  input  logic              long_pulse,
  output logic              rst_out
);

  localparam int MAX_TICKS = MAX_STEPS * TICKS_PER_STEP;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic [1:0]       sync_q;
  logic             btn_act;
  logic             treq_s;
  logic             tmr_en, tmr_clr, tmr_done;
  lpr_lim_e         lim_sel;
  logic             test_mode;
  logic             rst_act;
  logic [CNT_W-1:0] hold_lim, pulse_lim, cur_lim;

  // both inputs idle high through reset: button released, request "seen"
  lpr_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .por_n (por_n),
    .d     ({test_req, btn_n}),
    .q     (sync_q)
  );

  assign btn_act = !sync_q[0];
  assign treq_s  = sync_q[1];

  lpr_limits #(
    .CODE_W(CODE_W), .CNT_W(CNT_W), .TICKS_PER_STEP(TICKS_PER_STEP),
    .MAX_STEPS(MAX_STEPS), .TEST_SHIFT(TEST_SHIFT),
    .PULSE_SHORT(PULSE_SHORT), .PULSE_LONG(PULSE_LONG)
  ) u_limits (
    .delay_code (delay_code),
    .test_mode  (test_mode),
    .long_pulse (long_pulse),
    .hold_lim   (hold_lim),
    .pulse_lim  (pulse_lim)
  );

  always_comb begin
    unique case (lim_sel)
      LIM_PULSE: cur_lim = pulse_lim;
      LIM_ENTRY: cur_lim = CNT_W'(ENTRY_TICKS);
      default:   cur_lim = hold_lim;
    endcase
  end

  lpr_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .por_n (por_n),
    .tick  (tick_ms),
    .en    (tmr_en),
    .clr   (tmr_clr),
    .lim   (cur_lim),
    .done  (tmr_done)
  );

  lpr_fsm u_fsm (
    .clk         (clk),
    .por_n       (por_n),
    .btn_act     (btn_act),
    .treq_s      (treq_s),
    .fixed_pulse (fixed_pulse),
    .tmr_done    (tmr_done),
    .tmr_en      (tmr_en),
    .tmr_clr     (tmr_clr),
    .lim_sel     (lim_sel),
    .test_mode   (test_mode),
    .rst_act     (rst_act)
  );

  // R1: output polarity
  if (RST_ACTIVE_LOW) begin : g_low
    assign rst_out = !rst_act;
  end else begin : g_high
    assign rst_out = rst_act;
  end

endmodule

// File: tb/lpr_reset_ctrl_bench.sv
`timescale 1ns/1ps
module lpr_reset_ctrl_bench;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       tick_ms = 1'b0;
  logic       btn_n = 1'b1;
  logic       test_req = 1'b0;
  logic [4:0] delay_code = 5'd1;
  logic       fixed_pulse = 1'b0;
  logic       long_pulse = 1'b0;
  logic       rst_out;

  always #2 clk = ~clk;  // 250 MHz

  lpr_reset_ctrl u_lpr_reset_ctrl (
    .clk(clk), .por_n(por_n), .tick_ms(tick_ms), .btn_n(btn_n),
    .test_req(test_req), .delay_code(delay_code),
    .fixed_pulse(fixed_pulse), .long_pulse(long_pulse), .rst_out(rst_out)
  );

  // tick strobe every 4 cycles
  logic [1:0] tdiv = 2'd0;
  always @(posedge clk) begin
    tdiv    <= tdiv + 2'd1;
    tick_ms <= (tdiv == 2'd3);
  end

  typedef struct {
    int    start;
    int    lat_lo, lat_hi, len_lo, len_hi;
    string req_lat, req_len;
  } exp_t;

  exp_t  exp_q[$];
  int    n_checks = 0;
  int    n_err = 0;
  int    tick_total = 0;
  int    len_ctr = 0;
  bit    prev_act = 1'b0;
  bit    finished = 1'b0;
  string quiet_req = "R2";

  task automatic check(bit ok, string req, string what, int act_v, int exp_v);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act_v, exp_v);
    end
  endtask

  task automatic expect_pulse(int llo, int lhi, int nlo, int nhi, string rl, string rn);
    exp_t e;
    e.start = tick_total; e.lat_lo = llo; e.lat_hi = lhi;
    e.len_lo = nlo; e.len_hi = nhi; e.req_lat = rl; e.req_len = rn;
    exp_q.push_back(e);
  endtask

  // monitor: measures latency and width of each reset pulse, in ticks
  always @(negedge clk) begin
    bit act;
    if (tick_ms) tick_total++;
    act = (rst_out == 1'b0);
    if (act && !prev_act) begin
      len_ctr = 0;
      if (exp_q.size() == 0) begin
        check(1'b0, quiet_req, "unexpected reset pulse", 1, 0);
      end else begin
        int lat;
        lat = tick_total - exp_q[0].start;
        check(lat >= exp_q[0].lat_lo && lat <= exp_q[0].lat_hi,
              exp_q[0].req_lat, "assert latency", lat, exp_q[0].lat_lo);
      end
    end
    if (act && tick_ms) len_ctr++;
    if (!act && prev_act && exp_q.size() != 0) begin
      check(len_ctr >= exp_q[0].len_lo && len_ctr <= exp_q[0].len_hi,
            exp_q[0].req_len, "pulse width", len_ctr, exp_q[0].len_lo);
      void'(exp_q.pop_front());
    end
    prev_act = act;
  end

  task automatic tick_wait(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!tick_ms) @(negedge clk);
    end
  endtask

  task automatic set_btn(logic v);
    @(posedge clk); #1 btn_n = v;
  endtask

  task automatic set_req(logic v);
    @(posedge clk); #1 test_req = v;
  endtask

  task automatic wait_act();
    @(negedge clk);
    while (rst_out != 1'b0) @(negedge clk);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (rst_out != 1'b1) @(negedge clk);
  endtask

  task automatic do_por();
    @(posedge clk); #1 por_n = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(rst_out == 1'b1, "R1", "output during reset", rst_out, 1);
    @(posedge clk); #1 por_n = 1'b1;
    repeat (10) @(posedge clk);
  endtask

  // button-mode press: hold h ticks after assertion, then release
  task automatic btn_press(int lim, int h, string rl);
    set_btn(1'b0);
    expect_pulse(lim, lim + 1, h, h + 1, rl, "R4");
    wait_act();
    tick_wait(h);
    set_btn(1'b1);
    wait_idle();
    tick_wait(5);
  endtask

  initial begin
    do_por();
    @(negedge clk);
    check(rst_out == 1'b1, "R1", "output after reset", rst_out, 1);

    // R2: early release gives nothing, next press restarts from zero
    quiet_req = "R2";
    set_btn(1'b0);
    tick_wait(480);
    set_btn(1'b1);
    tick_wait(10);
    btn_press(500, 20, "R2");

    // R5 / R6: fixed 210, button held well past the delay
    fixed_pulse = 1'b1; long_pulse = 1'b0;
    set_btn(1'b0);
    expect_pulse(500, 501, 210, 210, "R2", "R5");
    quiet_req = "R6";
    wait_act();
    wait_idle();
    tick_wait(600);
    set_btn(1'b1);
    tick_wait(5);

    // R5: fixed 360, released early, code 2
    long_pulse = 1'b1; delay_code = 5'd2;
    set_btn(1'b0);
    expect_pulse(1000, 1001, 360, 360, "R2", "R5");
    wait_act();
    tick_wait(5);
    set_btn(1'b1);
    wait_idle();
    tick_wait(5);

    // R3: code 0 behaves as code 1
    fixed_pulse = 1'b0; delay_code = 5'd0;
    btn_press(500, 10, "R3");

    // R7: test entry with fixed feedback
    fixed_pulse = 1'b1; long_pulse = 1'b0; quiet_req = "R7";
    set_req(1'b1);
    expect_pulse(42, 43, 210, 210, "R7", "R7");
    wait_act();
    wait_idle();
    set_req(1'b0);
    tick_wait(5);

    // R8 / R3 in test mode, request already dropped (R9 sticky)
    fixed_pulse = 1'b0;
    delay_code = 5'd20; btn_press(78, 5, "R8");
    delay_code = 5'd31; btn_press(78, 5, "R3");
    delay_code = 5'd4;  btn_press(15, 5, "R8");
    delay_code = 5'd0;  btn_press(3, 5, "R3");

    // R9: a new request in test mode is ignored
    quiet_req = "R9";
    set_req(1'b1);
    tick_wait(60);
    set_req(1'b0);
    tick_wait(5);
    delay_code = 5'd1;
    btn_press(3, 5, "R9");

    // R10: request high while power-on reset releases
    set_req(1'b1);
    do_por();
    quiet_req = "R10";
    tick_wait(100);
    btn_press(500, 5, "R10");

    // R7: fresh entry, push-button feedback follows the request
    set_req(1'b0);
    tick_wait(5);
    quiet_req = "R7";
    set_req(1'b1);
    expect_pulse(42, 43, 30, 31, "R7", "R7");
    wait_act();
    tick_wait(30);
    set_req(1'b0);
    wait_idle();
    tick_wait(5);

    check(exp_q.size() == 0, "R2", "missing pulses", exp_q.size(), 0);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_err++;
      $display("FAIL R2 watchdog actual %0d expected %0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end

endmodule